// File: doc/BRIEF.md
# CPU Clock PLL Sequencer

This block holds the clock-control state that sits between a reference oscillator and the CPU clock. A PLL multiplies the oscillator, and a post-divider then sets the CPU clock rate. Software programs the multiplier and the post-divider through a small synchronous write port. It reads back the multiplier, the divider select, a lock flag, a sticky oscillator-missing flag and a detector-mask bit, all as plain outputs. Every change of the multiplier starts a lock period. Until that period ends, the CPU clock falls back to the oscillator divided by two. When the period ends, the CPU clock returns to the post-divided PLL clock.

The analog PLL is modelled behaviourally. A fast test clock stands in for the PLL output, and the post-divider is a toggle counter on that clock. The oscillator is sampled in the fast-clock domain. All logic runs on the fast clock. The fallback clock and the PLL clock meet in a glitch-free switch, so a change of source never produces a short pulse.

Top module: `cpuclk_pll_seq`

## Requirements
- R1: A multiplier write (address 0, data bits [MULT_W-1:0]) is accepted only while the divider select is 0. Otherwise it leaves the multiplier unchanged.
- R2: After reset the divider select is 0, the multiplier is RST_MULT, lock is 1, missing is 0, the detector mask is 0 and the CPU clock follows the PLL path.
- R3: The divider select (address 1, data bits [1:0]) sets the PLL-path CPU clock period in fast cycles. Selects 0 and 1 give divide-by-4 (period 8), select 2 gives divide-by-2 (period 4) and select 3 gives divide-by-1 (period 2).
- R4: An accepted multiplier write with a new value clears lock. Lock sets again after LOCK_CYCLES oscillator rising edges. A write of the current value changes nothing.
- R5: A write of a different multiplier value during a lock period restarts the full count.
- R6: While lock is 0 the CPU clock runs at the oscillator frequency divided by two. After lock it returns to the PLL path.
- R7: The missing flag sets when the oscillator shows no edge for more than MISS_LIMIT fast cycles. Only reset clears it.
- R8: The detector mask (address 2, data bit 0) holds the missing flag at 0 while it is 1.
- R9: Select 3 is accepted only while the current select is 2. From any other select, a write of 3 is ignored.
- R10: A change of clock source produces no CPU clock high or low phase shorter than the shorter half-period of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast test clock; stands in for the PLL output and clocks all logic |
| rst_n | input | 1 | Active-low reset |
| osc_in | input | 1 | Reference oscillator, asynchronous to fast_clk |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 multiplier, 1 divider select, 2 control |
| wr_data | input | DATA_W | Write data |
| cpu_clk | output | 1 | Generated CPU clock |
| cpu_on_pll | output | 1 | 1 when the CPU clock follows the PLL path |
| mult_o | output | MULT_W | Current multiplier |
| dsel_o | output | 2 | Current divider select |
| lock_o | output | 1 | PLL lock flag |
| miss_o | output | 1 | Sticky oscillator-missing flag |
| mask_o | output | 1 | Missing-detector mask bit |

## Verification
The bench goes after the refusal rules. A multiplier write with a nonzero select would alter the multiplier in a faulty design, and a jump to divide-by-1 from select 1 or 0 would produce a 2-cycle clock too early. It checks lock at a point past the first lock period but inside the restarted one, which exposes a counter that does not reload on a rewrite. It measures the clock period in fallback and after lock, and tracks every phase length across both source changes, so a switch taken while the output is high shows up as a runt pulse. It stops the oscillator with the mask set and then clears the mask, so a detector that ignores the mask or a flag that is not sticky is caught.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam logic [1:0] ADDR_MULT = 2'd0;
    localparam logic [1:0] ADDR_DSEL = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam logic [1:0] DSEL_DIV2 = 2'd2;
    localparam logic [1:0] DSEL_DIV1 = 2'd3;

    typedef enum logic [1:0] {
        SW_FOLLOW = 2'd0,
        SW_DRAIN  = 2'd1,
        SW_ALIGN  = 2'd2
    } sw_state_e;

    // half-period of the post-divided PLL clock, in fast cycles
    function automatic logic [2:0] post_half(input logic [1:0] sel);
        case (sel)
            DSEL_DIV1: post_half = 3'd1;
            DSEL_DIV2: post_half = 3'd2;
            default:   post_half = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/osc_monitor.sv
module osc_monitor #(
    parameter int MISS_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic mask,
    output logic rise_o,
    output logic miss_o
);
    localparam int IDLE_W = $clog2(MISS_LIMIT + 2);
    localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(MISS_LIMIT + 1);

    typedef struct packed {
        logic [2:0]        sync;
        logic [IDLE_W-1:0] idle;
        logic              miss;
    } mon_t;

    mon_t s_d, s_q;
    logic edge_any;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[1:0], osc_in};
        edge_any = s_q.sync[1] ^ s_q.sync[2];
        if (edge_any) begin
            s_d.idle = '0;
        end else if (s_q.idle != IDLE_TOP) begin
            s_d.idle = s_q.idle + 1'b1;
        end
        if (s_q.idle == IDLE_TOP && !mask) begin
            s_d.miss = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sync[1] & ~s_q.sync[2];
    assign miss_o = s_q.miss;

    p_miss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |=> miss_o);

    p_mask_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !miss_o) |=> !miss_o);

endmodule

// File: rtl/clk_sources.sv
module clk_sources
    import cpuclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_rise,
    input  logic [1:0] dsel,
    output logic       osc_half_o,
    output logic       pll_div_o
);
    typedef struct packed {
        logic       osc2;
        logic       pll;
        logic [2:0] cnt;
    } src_t;

    src_t s_d, s_q;
    logic [2:0] half_lim;

    always_comb begin
        s_d      = s_q;
        half_lim = post_half(dsel) - 3'd1;
        if (osc_rise) s_d.osc2 = ~s_q.osc2;
        if (s_q.cnt >= half_lim) begin
            s_d.cnt = '0;
            s_d.pll = ~s_q.pll;
        end else begin
            s_d.cnt = s_q.cnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign osc_half_o = s_q.osc2;
    assign pll_div_o  = s_q.pll;

    p_osc2_moves_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_rise |=> $stable(osc_half_o));

endmodule

// File: rtl/glitch_mux.sv
module glitch_mux
    import cpuclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_a,
    input  logic src_b,
    input  logic want_b,
    output logic clk_o,
    output logic on_b_o
);
    typedef struct packed {
        sw_state_e st;
        logic      act;
        logic      out;
        logic      prev;
    } mux_t;

    mux_t s_d, s_q;
    logic cur;

    always_comb begin
        s_d    = s_q;
        cur    = s_q.act ? src_b : src_a;
        s_d.prev = cur;
        case (s_q.st)
            SW_FOLLOW: begin
                s_d.out = cur;
                if (want_b != s_q.act) s_d.st = SW_DRAIN;
            end
            SW_DRAIN: begin
                s_d.out = cur;
                if (!s_q.out && !cur) begin
                    s_d.act  = want_b;
                    s_d.out  = 1'b0;
                    s_d.prev = want_b ? src_b : src_a;
                    s_d.st   = SW_ALIGN;
                end
            end
            default: begin
                s_d.out = 1'b0;
                if (s_q.prev && !cur) s_d.st = SW_FOLLOW;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SW_FOLLOW, act: 1'b1, out: 1'b0, prev: 1'b0};
        else        s_q <= s_d;
    end

    assign clk_o  = s_q.out;
    assign on_b_o = s_q.act;

    p_swap_while_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (on_b_o != $past(on_b_o)) |-> (!$past(clk_o) && !clk_o));

endmodule

// File: rtl/cpuclk_pll_seq.sv
module cpuclk_pll_seq
    import cpuclk_pkg::*;
#(
    parameter int MULT_W      = 4,
    parameter int DATA_W      = 8,
    parameter int LOCK_CYCLES = 1024,
    parameter int MISS_LIMIT  = 64,
    parameter int RST_MULT    = 1
) (
    input  logic              fast_clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cpu_clk,
    output logic              cpu_on_pll,
    output logic [MULT_W-1:0] mult_o,
    output logic [1:0]        dsel_o,
    output logic              lock_o,
    output logic              miss_o,
    output logic              mask_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [1:0]        dsel;
        logic              mask;
        logic              lock;
        logic [CNT_W-1:0]  cnt;
    } ctl_t;

    ctl_t c_d, c_q;
    logic osc_rise;
    logic osc_half, pll_div;
    logic [MULT_W-1:0] new_mult;
    logic [1:0] new_dsel;

    always_comb begin
        c_d      = c_q;
        new_mult = wr_data[MULT_W-1:0];
        new_dsel = wr_data[1:0];
        if (c_q.cnt != '0 && osc_rise) begin
            c_d.cnt = c_q.cnt - 1'b1;
            if (c_q.cnt == CNT_W'(1)) c_d.lock = 1'b1;
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_MULT: begin
                    if (c_q.dsel == 2'd0 && new_mult != c_q.mult) begin
                        c_d.mult = new_mult;
                        c_d.lock = 1'b0;
                        c_d.cnt  = CNT_LOAD;
                    end
                end
                ADDR_DSEL: begin
                    if (new_dsel != DSEL_DIV1 || c_q.dsel == DSEL_DIV2) begin
                        c_d.dsel = new_dsel;
                    end
                end
                ADDR_CTRL: c_d.mask = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{mult: MULT_W'(RST_MULT), dsel: 2'd0, mask: 1'b0,
                     lock: 1'b1, cnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    osc_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
        .clk    (fast_clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .mask   (c_q.mask),
        .rise_o (osc_rise),
        .miss_o (miss_o)
    );

    clk_sources u_src (
        .clk        (fast_clk),
        .rst_n      (rst_n),
        .osc_rise   (osc_rise),
        .dsel       (c_q.dsel),
        .osc_half_o (osc_half),
        .pll_div_o  (pll_div)
    );

    glitch_mux u_mux (
        .clk    (fast_clk),
        .rst_n  (rst_n),
        .src_a  (osc_half),
        .src_b  (pll_div),
        .want_b (c_q.lock),
        .clk_o  (cpu_clk),
        .on_b_o (cpu_on_pll)
    );

    assign mult_o = c_q.mult;
    assign dsel_o = c_q.dsel;
    assign lock_o = c_q.lock;
    assign mask_o = c_q.mask;

    p_mult_refused_r1: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MULT && dsel_o != 2'd0) |=> $stable(mult_o));

    p_lock_drops_r4: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (mult_o != $past(mult_o)) |-> !lock_o);

    p_div1_entry_r9: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (dsel_o == DSEL_DIV1 && $past(dsel_o) != DSEL_DIV1) |-> ($past(dsel_o) == DSEL_DIV2));

    p_lock_on_edge_r4: assert property (@(posedge fast_clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(osc_rise));

endmodule

// File: tb/sim_cpuclk_pll_seq.sv
module sim_cpuclk_pll_seq;
    localparam int CLK_PERIOD = 10;
    localparam int OSC_HALF   = 6;
    localparam int LOCK_N     = 64;
    localparam int MISS_N     = 40;
    localparam int OSC_PER    = 2 * OSC_HALF;

    logic       fast_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       osc_in   = 1'b0;
    logic       osc_run  = 1'b1;
    logic       wr_en    = 1'b0;
    logic [1:0] wr_addr  = '0;
    logic [7:0] wr_data  = '0;
    logic       cpu_clk, cpu_on_pll, lock_o, miss_o, mask_o;
    logic [3:0] mult_o;
    logic [1:0] dsel_o;

    typedef struct {
        string req;
        int    exp;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    // run-length tracker for R10
    logic track = 1'b0;
    logic trk_prev = 1'b0;
    int   trk_run = 1000;
    int   trk_min = 1000;

    cpuclk_pll_seq #(
        .MULT_W(4), .DATA_W(8), .LOCK_CYCLES(LOCK_N),
        .MISS_LIMIT(MISS_N), .RST_MULT(1)
    ) u0 (
        .fast_clk(fast_clk), .rst_n(rst_n), .osc_in(osc_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_clk(cpu_clk), .cpu_on_pll(cpu_on_pll), .mult_o(mult_o),
        .dsel_o(dsel_o), .lock_o(lock_o), .miss_o(miss_o), .mask_o(mask_o)
    );

    always #(CLK_PERIOD / 2) fast_clk = ~fast_clk;

    initial begin
        forever begin
            repeat (OSC_HALF) @(negedge fast_clk);
            if (osc_run) osc_in = ~osc_in;
        end
    end

    always @(negedge fast_clk) begin
        if (track) begin
            if (cpu_clk == trk_prev) begin
                trk_run++;
            end else begin
                if (trk_run < trk_min) trk_min = trk_run;
                trk_run = 1;
            end
        end
        trk_prev = cpu_clk;
    end

    // driver side: queue the expected value
    task automatic expect_item(input string req, input int exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor side: pop and compare against what the design shows
    task automatic observe(input int act);
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", it.req, act, it.exp);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        expect_item(req, exp);
        observe(act);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge fast_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge fast_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(output int cycles);
        logic prev;
        prev = cpu_clk;
        cycles = 0;
        forever begin
            @(negedge fast_clk);
            cycles++;
            if ((!prev && cpu_clk) || cycles > 2000) break;
            prev = cpu_clk;
        end
    endtask

    task automatic period(output int p);
        int dummy;
        wait_rise(dummy);
        wait_rise(p);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int p;
        repeat (5) @(negedge fast_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge fast_clk);

        // R2 reset state
        chk("R2 dsel", dsel_o, 0);
        chk("R2 mult", mult_o, 1);
        chk("R2 lock", lock_o, 1);
        chk("R2 miss", miss_o, 0);
        chk("R2 mask", mask_o, 0);
        chk("R2 pll path", cpu_on_pll, 1);

        // R3 select 0 and 1 give period 8
        period(p); chk("R3 sel0 period", p, 8);
        wr(2'd1, 8'd1);
        period(p); chk("R3 sel1 period", p, 8);

        // R9 jump from 1 to 3 refused
        wr(2'd1, 8'd3);
        chk("R9 sel1->3 refused", dsel_o, 1);

        wr(2'd1, 8'd2);
        period(p); chk("R3 sel2 period", p, 4);

        // R1 multiplier write refused with nonzero select
        wr(2'd0, 8'd5);
        repeat (2) @(negedge fast_clk);
        chk("R1 mult held", mult_o, 1);
        chk("R1 lock untouched", lock_o, 1);

        wr(2'd1, 8'd3);
        chk("R9 sel2->3 accepted", dsel_o, 3);
        period(p); chk("R3 sel3 period", p, 2);

        wr(2'd1, 8'd0);
        wr(2'd1, 8'd3);
        chk("R9 sel0->3 refused", dsel_o, 0);

        // R4 / R6 / R10 lock sequence
        trk_run = 1000; trk_min = 1000; track = 1'b1;
        wr(2'd0, 8'd5);
        chk("R1 mult accepted at sel0", mult_o, 5);
        chk("R4 lock cleared", lock_o, 0);
        repeat (100) @(negedge fast_clk);
        chk("R6 fallback path", cpu_on_pll, 0);
        period(p); chk("R6 fallback period", p, 2 * OSC_PER);
        repeat (560) @(negedge fast_clk);
        chk("R4 still counting", lock_o, 0);
        repeat (100) @(negedge fast_clk);
        chk("R4 locked", lock_o, 1);
        repeat (100) @(negedge fast_clk);
        chk("R6 back on pll", cpu_on_pll, 1);
        period(p); chk("R6 pll period", p, 8);
        track = 1'b0;
        chk("R10 shortest phase >= 4", (trk_min >= 4) ? 1 : 0, 1);

        // R4 same-value write has no effect
        wr(2'd0, 8'd5);
        repeat (3) @(negedge fast_clk);
        chk("R4 same value keeps lock", lock_o, 1);

        // R5 restart on rewrite
        wr(2'd0, 8'd7);
        repeat (30 * OSC_PER) @(negedge fast_clk);
        wr(2'd0, 8'd9);
        repeat ((LOCK_N - 4) * OSC_PER) @(negedge fast_clk);
        chk("R5 restarted count", lock_o, 0);
        repeat (10 * OSC_PER) @(negedge fast_clk);
        chk("R5 locked after restart", lock_o, 1);
        chk("R5 final mult", mult_o, 9);

        // R8 mask suppresses detection
        wr(2'd2, 8'd1);
        chk("R8 mask set", mask_o, 1);
        osc_run = 1'b0;
        repeat (4 * MISS_N) @(negedge fast_clk);
        chk("R8 masked no flag", miss_o, 0);

        // R7 detection and stickiness
        wr(2'd2, 8'd0);
        repeat (5) @(negedge fast_clk);
        chk("R7 flag set", miss_o, 1);
        osc_run = 1'b1;
        repeat (100) @(negedge fast_clk);
        chk("R7 flag sticky", miss_o, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge fast_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge fast_clk);
        chk("R7 reset clears flag", miss_o, 0);
        chk("R2 mult after reset", mult_o, 1);

        finish_run();
    end

endmodule